// File: doc/BRIEF.md
# SEC-DED Hamming Codec for Byte-Wide Memory

This block guards an 8-bit memory word with a Hamming code that corrects any single flipped bit and detects two flipped bits. It has two independent channels. The encode channel takes a data byte and returns a 13-bit word to store. The decode channel takes a 13-bit word fetched from memory and returns the data, repaired where the error is repairable. With the data it returns a corrected flag, an uncorrectable flag and the raw syndrome.

The check bits sit at the power-of-two positions of a 12-bit Hamming word. Because of this, a nonzero syndrome read as a binary number names the position that flipped. An extra even-parity bit covers the whole stored word. It separates a correctable single error, where parity is broken, from a double error, where parity still holds but the syndrome is nonzero.

Each channel is a valid/ready stream with one register stage. A channel accepts an input on a clock edge where `*_in_valid` and `*_in_ready` are both high. Its result appears registered on the next cycle. An output that is offered while the consumer holds ready low stays frozen until it is taken. The input ready of a channel is high whenever its output register is empty or is being drained in the same cycle, so a continuously ready consumer sees full throughput. While ready is low, the producer must keep valid and data steady.

Top module: `ecc_codec`

## Requirements
- R1: The stored word uses this layout. Bit p (1..12) holds Hamming position p. Positions 1, 2, 4 and 8 hold check bits C1, C2, C4 and C8. Positions 3, 5, 6, 7, 9, 10, 11 and 12 hold data bits 0 through 7, in that order. The check bits are C1 = d0^d1^d3^d4^d6, C2 = d0^d2^d3^d5^d6, C4 = d1^d2^d3^d7 and C8 = d4^d5^d6^d7. Bit 0 is chosen so that the XOR of all 13 bits is 0.
- R2: The syndrome bit j is the XOR of every fetched bit whose position 1..12 has bit j set. An intact word gives syndrome 0 and both flags low, and the data passes through unchanged.
- R3: A single flip at a data position gives a syndrome equal to that position. The decoder returns the original byte with the corrected flag high and the uncorrectable flag low.
- R4: A single flip at position 1, 2, 4 or 8, or at parity bit 0, leaves the data bits untouched. It sets the corrected flag and reports a syndrome equal to the position, which is 0 for the parity bit.
- R5: A nonzero syndrome with intact overall parity raises the uncorrectable flag. The corrected flag stays low, and the data bits are passed through exactly as fetched.
- R6: A syndrome above 12 with broken overall parity also raises only the uncorrectable flag, with the data bits passed through as fetched.
- R7: The corrected and uncorrectable flags are never high together.
- R8: A result is valid on the output one cycle after its input is accepted. While valid is high and ready is low, the output stays valid and all its fields hold their values.
- R9: A channel's input ready equals the inverse of its output valid, ORed with its output ready.
- R10: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_in_valid | input | 1 | Data byte offered for encoding |
| enc_in_ready | output | 1 | Encode channel can accept |
| enc_in_data | input | 8 | Byte to protect |
| enc_out_valid | output | 1 | Stored word available |
| enc_out_ready | input | 1 | Consumer takes the stored word |
| enc_out_code | output | 13 | Word to store, layout per R1 |
| dec_in_valid | input | 1 | Fetched word offered for checking |
| dec_in_ready | output | 1 | Decode channel can accept |
| dec_in_code | input | 13 | Word read from memory |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the decode result |
| dec_out_data | output | 8 | Data byte, repaired when correctable |
| dec_out_corrected | output | 1 | A correctable error was seen |
| dec_out_uncorrectable | output | 1 | An error beyond repair was seen |
| dec_out_syndrome | output | 4 | Raw syndrome of the fetched word |

## Verification
Every result is due exactly one cycle after its handshake. Inputs change on the falling edge, and the bench reads the outputs one time unit later, before the next rising edge. At that point it checks three things: an accept in the previous cycle must show up as valid now, a result stalled in the previous cycle must reappear unchanged, and a result being taken now must match the front of an expected queue. The expected values come from the bench's own encoder equations and from the set of injected bit flips, not from recomputing the design's syndrome logic.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  // Smallest k with 2^k - 1 >= m + k
  function automatic int chk_bits(input int m);
    int k;
    k = 1;
    while (((1 << k) - 1) < (m + k)) k++;
    return k;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Hamming position (1-based) of data bit i
  function automatic int data_pos(input int i);
    int p;
    int seen;
    p = 0;
    seen = -1;
    while (seen < i) begin
      p++;
      if (!is_pow2(p)) seen++;
    end
    return p;
  endfunction

endpackage

// File: rtl/ecc_stage.sv
module ecc_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_payload == $past(in_payload)));

endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] word;

  always_comb begin
    word = '0;
    for (int i = 0; i < DATA_W; i++)
      word[ecc_pkg::data_pos(i)] = data[i];
    for (int j = 0; j < CHK_W; j++)
      for (int p = 1; p <= HAM_W; p++)
        if (((p >> j) & 1) != 0 && !ecc_pkg::is_pow2(p))
          word[1 << j] = word[1 << j] ^ word[p];
    word[0] = ^word[HAM_W:1];
    code = word;
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              corrected,
  output logic              uncorrectable,
  output logic [CHK_W-1:0]  syndrome
);
  logic [CODE_W-1:0] repaired;
  logic              par_bad;

  always_comb begin
    syndrome = '0;
    for (int j = 0; j < CHK_W; j++)
      for (int p = 1; p <= HAM_W; p++)
        if (((p >> j) & 1) != 0)
          syndrome[j] = syndrome[j] ^ code[p];
    par_bad       = ^code;
    repaired      = code;
    corrected     = 1'b0;
    uncorrectable = 1'b0;
    if (par_bad) begin
      if (int'(syndrome) > HAM_W) begin
        uncorrectable = 1'b1;
      end else begin
        corrected = 1'b1;
        for (int p = 1; p <= HAM_W; p++)
          if (int'(syndrome) == p) repaired[p] = ~code[p];
      end
    end else if (syndrome != '0) begin
      uncorrectable = 1'b1;
    end
    for (int i = 0; i < DATA_W; i++)
      data[i] = repaired[ecc_pkg::data_pos(i)];
  end

endmodule

// File: rtl/ecc_codec.sv
module ecc_codec #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = ecc_pkg::chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_W + 1,
  localparam int RES_W  = DATA_W + 2 + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic              dec_out_corrected,
  output logic              dec_out_uncorrectable,
  output logic [CHK_W-1:0]  dec_out_syndrome
);
  logic [CODE_W-1:0] enc_code_c;
  logic [DATA_W-1:0] dec_data_c;
  logic              dec_corr_c;
  logic              dec_unc_c;
  logic [CHK_W-1:0]  dec_syn_c;
  logic [RES_W-1:0]  dec_res_q;

  ecc_encoder #(.DATA_W(DATA_W)) u_enc (
    .data (enc_in_data),
    .code (enc_code_c)
  );

  ecc_stage #(.WIDTH(CODE_W)) u_enc_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (enc_in_valid),
    .in_ready    (enc_in_ready),
    .in_payload  (enc_code_c),
    .out_valid   (enc_out_valid),
    .out_ready   (enc_out_ready),
    .out_payload (enc_out_code)
  );

  ecc_decoder #(.DATA_W(DATA_W)) u_dec (
    .code          (dec_in_code),
    .data          (dec_data_c),
    .corrected     (dec_corr_c),
    .uncorrectable (dec_unc_c),
    .syndrome      (dec_syn_c)
  );

  ecc_stage #(.WIDTH(RES_W)) u_dec_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (dec_in_valid),
    .in_ready    (dec_in_ready),
    .in_payload  ({dec_data_c, dec_corr_c, dec_unc_c, dec_syn_c}),
    .out_valid   (dec_out_valid),
    .out_ready   (dec_out_ready),
    .out_payload (dec_res_q)
  );

  assign {dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome} = dec_res_q;

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !(dec_out_corrected && dec_out_uncorrectable));

  assert_zero_syn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_syndrome == '0) |-> !dec_out_uncorrectable);

  assert_high_syn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && int'(dec_out_syndrome) > HAM_W) |-> (dec_out_uncorrectable && !dec_out_corrected));

  assert_stored_parity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> !(^enc_out_code));

  assert_enc_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && dec_in_ready && !dec_unc_c && !dec_corr_c) |=> (dec_out_syndrome == '0));

endmodule

// File: tb/tb_ecc_codec.sv
module tb_ecc_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic        enc_in_ready;
  logic [7:0]  enc_in_data = '0;
  logic        enc_out_valid;
  logic        enc_out_ready = 1'b0;
  logic [12:0] enc_out_code;
  logic        dec_in_valid = 1'b0;
  logic        dec_in_ready;
  logic [12:0] dec_in_code = '0;
  logic        dec_out_valid;
  logic        dec_out_ready = 1'b0;
  logic [7:0]  dec_out_data;
  logic        dec_out_corrected;
  logic        dec_out_uncorrectable;
  logic [3:0]  dec_out_syndrome;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ecc_codec dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [12:0] ref_enc(input logic [7:0] d);
    logic [12:0] w;
    w = '0;
    w[3] = d[0]; w[5] = d[1]; w[6] = d[2]; w[7] = d[3];
    w[9] = d[4]; w[10] = d[5]; w[11] = d[6]; w[12] = d[7];
    w[1] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    w[2] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    w[4] = d[1] ^ d[2] ^ d[3] ^ d[7];
    w[8] = d[4] ^ d[5] ^ d[6] ^ d[7];
    w[0] = ^w[12:1];
    return w;
  endfunction

  function automatic logic [7:0] pick_data(input logic [12:0] w);
    return {w[12], w[11], w[10], w[9], w[7], w[6], w[5], w[3]};
  endfunction

  // expected {data, corrected, uncorrectable, syndrome} from the injected flips
  function automatic logic [13:0] ref_dec(input logic [7:0] d, input logic [12:0] m);
    logic [3:0]  s;
    logic [12:0] rx;
    logic        odd;
    s = '0;
    for (int p = 1; p <= 12; p++) if (m[p]) s = s ^ 4'(p);
    odd = ^m;
    rx  = ref_enc(d) ^ m;
    if (odd && s <= 4'd12) begin
      if (s != 0) rx[s] = ~rx[s];
      return {pick_data(rx), 1'b1, 1'b0, s};
    end
    if (odd || s != 0) return {pick_data(rx), 1'b0, 1'b1, s};
    return {pick_data(rx), 1'b0, 1'b0, s};
  endfunction

  function automatic logic [12:0] rand_mask();
    logic [12:0] m;
    int w;
    m = '0;
    w = $urandom_range(0, 3);
    while ($countones(m) < w) m[$urandom_range(0, 12)] = 1'b1;
    return m;
  endfunction

  localparam int NDIR = 21;
  logic [12:0] dir_mask [NDIR];
  initial begin
    dir_mask[0] = '0;
    for (int p = 0; p < 13; p++) dir_mask[p + 1] = 13'(1) << p;  // R3 / R4
    dir_mask[14] = 13'b0_0000_0010_1000;  // R5 positions 3,5
    dir_mask[15] = 13'b0_0000_0000_0110;  // R5 positions 1,2
    dir_mask[16] = 13'b0_0001_0010_0001;  // R6 positions 0,5,8 -> 13
    dir_mask[17] = 13'b0_0010_0100_0001;  // R6 positions 0,6,9 -> 15
    dir_mask[18] = 13'b0_0000_1001_0110;  // R2 four flips, syndrome 0
    dir_mask[19] = 13'b1_0000_0000_1000;  // R5 positions 3,12
    dir_mask[20] = 13'b0_0000_0000_0011;  // R4 check+parity -> double
  end

  logic [12:0] enc_q [$];
  logic [13:0] dec_q [$];

  initial begin
    logic [7:0]  dd;
    logic [12:0] mm;
    logic        enc_acc = 0, dec_acc = 0;
    logic        enc_stall = 0, dec_stall = 0;
    logic [12:0] enc_held = '0;
    logic [13:0] dec_held = '0;
    int          dir_i = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 enc_out_valid", enc_out_valid, 0);
    chk("R10 dec_out_valid", dec_out_valid, 0);
    chk("R10 enc_in_ready", enc_in_ready, 1);
    chk("R10 dec_in_ready", dec_in_ready, 1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!enc_in_valid || enc_acc) begin
        enc_in_valid = ($urandom_range(0, 3) != 0);
        enc_in_data  = 8'($urandom);
      end
      if (!dec_in_valid || dec_acc) begin
        dd = 8'($urandom);
        if (dir_i < NDIR) begin
          mm = dir_mask[dir_i];
          dec_in_valid = 1'b1;
          dir_i++;
        end else begin
          mm = rand_mask();
          dec_in_valid = ($urandom_range(0, 3) != 0);
        end
        dec_in_code = ref_enc(dd) ^ mm;
      end
      enc_out_ready = (cyc < 40) || ($urandom_range(0, 2) != 0);
      dec_out_ready = (cyc < 40) || ($urandom_range(0, 2) != 0);
      #1;
      // R9 ready rule
      chk("R9 enc_in_ready", enc_in_ready, !enc_out_valid || enc_out_ready);
      chk("R9 dec_in_ready", dec_in_ready, !dec_out_valid || dec_out_ready);
      // R8 latency and hold
      if (enc_acc) chk("R8 enc latency", enc_out_valid, 1);
      if (dec_acc) chk("R8 dec latency", dec_out_valid, 1);
      if (enc_stall) chk("R8 enc hold", {enc_out_valid, enc_out_code}, {1'b1, enc_held});
      if (dec_stall)
        chk("R8 dec hold", {dec_out_valid, dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome},
            {1'b1, dec_held});
      if (enc_out_valid && enc_out_ready) begin
        if (enc_q.size() == 0) chk("R8 enc spurious", 1, 0);
        else chk("R1 code", enc_out_code, enc_q.pop_front());
      end
      if (dec_out_valid && dec_out_ready) begin
        if (dec_q.size() == 0) chk("R8 dec spurious", 1, 0);
        else begin
          logic [13:0] e;
          e = dec_q.pop_front();
          if (e[5]) chk("R3 R4 corrected result", {dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome}, e);
          else if (e[4]) chk("R5 R6 uncorrectable result", {dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome}, e);
          else chk("R2 clean result", {dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome}, e);
          chk("R7 flags exclusive", dec_out_corrected & dec_out_uncorrectable, 0);
        end
      end
      enc_stall = enc_out_valid && !enc_out_ready;
      dec_stall = dec_out_valid && !dec_out_ready;
      enc_held  = enc_out_code;
      dec_held  = {dec_out_data, dec_out_corrected, dec_out_uncorrectable, dec_out_syndrome};
      enc_acc = enc_in_valid && enc_in_ready;
      dec_acc = dec_in_valid && dec_in_ready;
      if (enc_acc) enc_q.push_back(ref_enc(enc_in_data));
      if (dec_acc) dec_q.push_back(ref_dec(dd, dec_in_code ^ ref_enc(dd)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule